// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Register

This block is the arithmetic and logic stage of an 8-bit accumulator machine. Each cycle it takes the accumulator value `a`, a second operand `b`, a 4-bit operation code and the flag byte currently held by the processor. From these it computes a result byte and a write-enable for the accumulator. Both outputs are combinational.

The block also computes a new flag byte. On a clock edge where `go` is high, that byte is captured into the flag register. The flag rules are exact and follow each operation. They cover the two undocumented copy bits (5 and 3), half-carry, parity/overflow, subtract and carry. Increment and decrement leave carry alone. Set-carry and complement-carry take the copy bits from the accumulator. Any flag an operation does not define is passed through from `flags_in`.

Top module: `alu8_flags`

## Requirements
- R1: Operation codes are: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 increment `a`, 9 decrement `a`, 10 negate `a`, 11 complement `a`, 12 set carry, 13 complement carry. The flag byte is laid out from bit 7 down as sign, zero, copy-5, half-carry, copy-3, parity/overflow, subtract, carry.
- R2: Reset clears `flags_out` to 0x00. On a clock edge with `go` high, `flags_out` loads the newly computed flags. With `go` low it holds its value.
- R3: Add and add-with-carry give `a+b+cin`, where cin is `flags_in[0]` for code 1 and 0 otherwise. H is the carry out of bit 3, C is the carry out of bit 7, P/V is signed overflow and N is 0.
- R4: Subtract and subtract-with-borrow give `a-b-cin`. N is 1, H is the borrow into bit 4, C is set when `b+cin` exceeds `a`, and P/V is signed overflow.
- R5: Compare produces the subtract flags of `a-b` on `result`, and `wr_en` is 0.
- R6: For every operation except set carry and complement carry, S, Z, bit 5 and bit 3 follow the result. Set carry and complement carry take bits 5 and 3 from `a` and keep S, Z and P/V.
- R7: AND sets H. OR and XOR clear H. All three clear N and C, and set P/V when the result has even parity.
- R8: Increment sets P/V when `a` was 0x7F and H when the low nibble of `a` was 0xF. N is cleared and C is kept.
- R9: Decrement sets P/V when `a` was 0x80 and H when the low nibble of `a` was 0x0. N is set and C is kept.
- R10: Negate gives `0-a`. It sets N, sets P/V when `a` was 0x80, sets C when `a` was nonzero, and sets H when the low nibble of `a` was nonzero.
- R11: Complement gives `~a` and sets H and N. It keeps S, Z, P/V and C.
- R12: Set carry sets C and clears H and N. Complement carry copies the old C into H, inverts C and clears N. Neither one writes the accumulator.
- R13: Codes 14 and 15 pass `a` to `result`, hold `wr_en` low and leave every flag equal to `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Load the computed flags on this edge |
| op | input | 4 | Operation code |
| a | input | 8 | Accumulator operand |
| b | input | 8 | Second operand |
| flags_in | input | 8 | Current flag byte |
| result | output | 8 | Computed result byte |
| wr_en | output | 1 | Accumulator write enable |
| flags_out | output | 8 | Registered flag byte |

## Verification
Some properties are checked on every cycle. The flag register holds while `go` is low. A compare sets Z exactly when its operands match. The logic operations clear N and C and report even parity of their result. Increment and decrement carry C through, complement sets H and N, and the spare codes pass the incoming flags through unchanged. Other behaviour can only be shown by the bench's vectors with worked-out expected values. This includes the exact half-carry, overflow and borrow boundaries (0x7F, 0x80, nibble wrap, borrow-in), the negate rules, and where the copy bits come from.

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [3:0] op,
  input  logic [7:0] a,
  input  logic [7:0] b,
  input  logic [7:0] flags_in,
  output logic [7:0] result,
  output logic       wr_en,
  output logic [7:0] flags_out
);
  localparam logic [3:0] OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3;
  localparam logic [3:0] OP_CMP = 4'd4,  OP_AND = 4'd5,  OP_OR  = 4'd6,  OP_XOR = 4'd7;
  localparam logic [3:0] OP_INC = 4'd8,  OP_DEC = 4'd9,  OP_NEG = 4'd10, OP_CPL = 4'd11;
  localparam logic [3:0] OP_SCF = 4'd12, OP_CCF = 4'd13;

  logic [7:0] x, y, yy;
  logic       ci, sub, cc;
  logic [4:0] lo;
  logic [7:0] mid;
  logic [8:0] full;
  logic       h_ar, c_ar, v_ar;
  logic [7:0] nf;

  always_comb begin
    x = a; y = b; ci = 1'b0; sub = 1'b0;
    case (op)
      OP_ADC: ci = flags_in[0];
      OP_SUB, OP_CMP: sub = 1'b1;
      OP_SBC: begin sub = 1'b1; ci = flags_in[0]; end
      OP_INC: y = 8'h01;
      OP_DEC: begin y = 8'h01; sub = 1'b1; end
      OP_NEG: begin x = 8'h00; y = a; sub = 1'b1; end
      default: ;
    endcase
  end

  assign yy   = sub ? ~y : y;
  assign cc   = ci ^ sub;
  assign lo   = {1'b0, x[3:0]} + {1'b0, yy[3:0]} + {4'b0, cc};
  assign mid  = {1'b0, x[6:0]} + {1'b0, yy[6:0]} + {7'b0, cc};
  assign full = {1'b0, x} + {1'b0, yy} + {8'b0, cc};
  assign h_ar = lo[4] ^ sub;
  assign c_ar = full[8] ^ sub;
  assign v_ar = mid[7] ^ full[8];

  always_comb begin
    result = a;
    wr_en  = 1'b0;
    nf     = flags_in;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_INC, OP_DEC, OP_NEG: begin
        result = full[7:0];
        wr_en  = (op != OP_CMP);
        nf = {full[7], full[7:0] == 8'h00, full[5], h_ar, full[3], v_ar, sub, c_ar};
        if (op == OP_INC || op == OP_DEC) nf[0] = flags_in[0];
      end
      OP_AND, OP_OR, OP_XOR: begin
        result = (op == OP_AND) ? (a & b) : (op == OP_OR) ? (a | b) : (a ^ b);
        wr_en  = 1'b1;
        nf = {result[7], result == 8'h00, result[5], op == OP_AND, result[3], ~^result, 2'b00};
      end
      OP_CPL: begin
        result = ~a;
        wr_en  = 1'b1;
        nf[5] = ~a[5]; nf[4] = 1'b1; nf[3] = ~a[3]; nf[1] = 1'b1;
      end
      OP_SCF: begin
        nf[5] = a[5]; nf[4] = 1'b0; nf[3] = a[3]; nf[1] = 1'b0; nf[0] = 1'b1;
      end
      OP_CCF: begin
        nf[5] = a[5]; nf[4] = flags_in[0]; nf[3] = a[3]; nf[1] = 1'b0; nf[0] = ~flags_in[0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  flags_out <= 8'h00;
    else if (go) flags_out <= nf;

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(flags_out));

  // R5
  cmp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_CMP) |=> (flags_out[6] == ($past(a) == $past(b))) && flags_out[1]);

  // R7
  logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (op == OP_AND || op == OP_OR || op == OP_XOR))
      |=> (flags_out[1:0] == 2'b00) && (flags_out[2] == ~^$past(result)));

  // R8 and R9
  incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (op == OP_INC || op == OP_DEC)) |=> flags_out[0] == $past(flags_in[0]));

  // R11
  cpl_hn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_CPL) |=> flags_out[4] && flags_out[1]);

  // R13
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op > OP_CCF) |=> flags_out == $past(flags_in));
endmodule

// File: tb/test_alu8_flags.sv
module test_alu8_flags;
  localparam int PERIOD = 10;
  localparam int NV = 26;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] a = 8'h00, b = 8'h00, flags_in = 8'h00;
  logic [7:0] result, flags_out;
  logic wr_en;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  alu8_flags i_alu8_flags (.clk(clk), .rst_n(rst_n), .go(go), .op(op), .a(a), .b(b),
    .flags_in(flags_in), .result(result), .wr_en(wr_en), .flags_out(flags_out));

  // op, a, b, flags_in, expected result, expected wr_en, expected flags
  localparam logic [44:0] VEC [NV] = '{
    {4'd0,  8'h44, 8'h3C, 8'h00, 8'h80, 1'b1, 8'h94},
    {4'd1,  8'hFF, 8'h00, 8'h01, 8'h00, 1'b1, 8'h51},
    {4'd0,  8'h2A, 8'h0E, 8'hFF, 8'h38, 1'b1, 8'h38},
    {4'd2,  8'h10, 8'h20, 8'h00, 8'hF0, 1'b1, 8'hA3},
    {4'd3,  8'h80, 8'h00, 8'h01, 8'h7F, 1'b1, 8'h3E},
    {4'd4,  8'h42, 8'h42, 8'h01, 8'h00, 1'b0, 8'h42},
    {4'd5,  8'hF0, 8'h3C, 8'h03, 8'h30, 1'b1, 8'h34},
    {4'd6,  8'h01, 8'h02, 8'hFF, 8'h03, 1'b1, 8'h04},
    {4'd7,  8'h5A, 8'h5A, 8'hFF, 8'h00, 1'b1, 8'h44},
    {4'd7,  8'h08, 8'h00, 8'h00, 8'h08, 1'b1, 8'h08},
    {4'd8,  8'h7F, 8'h00, 8'h01, 8'h80, 1'b1, 8'h95},
    {4'd8,  8'hFF, 8'h00, 8'h00, 8'h00, 1'b1, 8'h50},
    {4'd9,  8'h80, 8'h00, 8'h00, 8'h7F, 1'b1, 8'h3E},
    {4'd9,  8'h01, 8'h00, 8'h01, 8'h00, 1'b1, 8'h43},
    {4'd10, 8'h01, 8'h00, 8'h00, 8'hFF, 1'b1, 8'hBB},
    {4'd10, 8'h80, 8'h00, 8'h00, 8'h80, 1'b1, 8'h87},
    {4'd10, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h42},
    {4'd11, 8'h55, 8'h00, 8'h00, 8'hAA, 1'b1, 8'h3A},
    {4'd11, 8'h55, 8'h00, 8'hC5, 8'hAA, 1'b1, 8'hFF},
    {4'd12, 8'h28, 8'h00, 8'hD6, 8'h28, 1'b0, 8'hED},
    {4'd13, 8'h00, 8'h00, 8'h01, 8'h00, 1'b0, 8'h10},
    {4'd13, 8'h20, 8'h00, 8'hC4, 8'h20, 1'b0, 8'hE5},
    {4'd14, 8'h33, 8'h11, 8'h5A, 8'h33, 1'b0, 8'h5A},
    {4'd15, 8'h99, 8'h11, 8'hA5, 8'h99, 1'b0, 8'hA5},
    {4'd2,  8'h05, 8'h05, 8'hFF, 8'h00, 1'b1, 8'h42},
    {4'd3,  8'h00, 8'hFF, 8'h01, 8'h00, 1'b1, 8'h53}
  };

  function automatic string req_of(input logic [3:0] code);
    case (code)
      4'd0, 4'd1:   return "R3";
      4'd2, 4'd3:   return "R4";
      4'd4:         return "R5";
      4'd5, 4'd6, 4'd7: return "R7";
      4'd8:         return "R8";
      4'd9:         return "R9";
      4'd10:        return "R10";
      4'd11:        return "R11";
      4'd12, 4'd13: return "R12";
      default:      return "R13";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R2", "reset flags", flags_out, 8'h00);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {op, a, b, flags_in} = VEC[i][44:17];
      go = 1'b1;
      #1;
      check(req_of(op), $sformatf("result v%0d", i), result, VEC[i][16:9]);
      check(req_of(op), $sformatf("wr_en v%0d", i), {7'b0, wr_en}, {7'b0, VEC[i][8]});
      @(posedge clk);
      #1;
      // R1 R6: flag layout and copy bits are part of every expected byte
      check(req_of(op), $sformatf("flags v%0d", i), flags_out, VEC[i][7:0]);
    end
    // R2: hold with go low
    @(negedge clk);
    go = 1'b0; op = 4'd0; a = 8'h7F; b = 8'h01; flags_in = 8'h00;
    @(posedge clk); #1;
    check("R2", "hold go low", flags_out, 8'h53);
    @(posedge clk); #1;
    check("R2", "hold second edge", flags_out, 8'h53);
    // R2: reset mid-run clears register
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R2", "async reset", flags_out, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule